// File: doc/BRIEF.md
# Line-Parallel Full-Search SAD Motion Estimator

This block runs an exhaustive block-matching search for one current block of N x N pixels over a square range of displacements from -w to +w in both directions. It holds 2w+1 processing elements side by side. Each element owns one horizontal displacement of the line now being scored and sums absolute pixel differences for it. One current-block pixel is broadcast to all elements per accepted cycle. In the same cycle each element is given its own search-window pixel by an external window buffer. The current block is presented column by column: the row index runs fastest and the column index slowest.

When the N*N-th pixel of a line is accepted, the element sums are copied into a separate result chain, and the accumulators are free for the next line at once. The chain moves one result per cycle into a minimum comparator. The comparator keeps the smallest distortion seen so far and the signed displacement that produced it. After 2w+1 lines the whole search range has been scored. The block then raises a one-cycle done pulse, with the winning distortion and vector on its outputs. The reset is asynchronous and active low. Its release is synchronised inside the block, so the block accepts pixels from the third rising edge after release.

Top module: `sad_line_array`

## Requirements
- R1: Element k (0..2w) sums |ref_pix - win_pix[k*PIX_W +: PIX_W]| over the N*N accepted pixels of a line and scores horizontal displacement n = k - w.
- R2: A cycle with pix_valid and line_start high starts a new line. It clears every accumulator and the pixel count before adding the current pixel, so a partly sent line is discarded. line_start with pix_valid low has no effect.
- R3: Cycles with pix_valid low leave the accumulators, the pixel count and the result unchanged.
- R4: Lines are numbered 0..2w from reset, and line l scores vertical displacement m = l - w. The line number returns to 0 after line 2w, so searches may follow each other with no gap.
- R5: The cycle after the last pixel of a line, the finished sums enter the result chain. They are compared one per cycle in element order. The next line may begin in that same cycle.
- R6: The comparator scans in the order line 0..2w, and within a line element 0..2w. It replaces the kept minimum only on a strictly smaller distortion, so among equal distortions the first in that order wins.
- R7: srch_done is high for exactly one cycle. That cycle is 2w+1 cycles after the edge that accepts the last pixel of line 2w. In that cycle best_sad is the minimum distortion, and best_m and best_n are its displacements in two's complement, each within -w..+w.
- R8: Distortion width is PIX_W + clog2(N*N) bits. This holds the largest possible sum N*N*(2^PIX_W - 1) without wrap.
- R9: While reset is active and after it, srch_done is low, best_sad, best_m and best_n are zero, and the line number is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | A broadcast pixel and window pixels are present this cycle |
| line_start | input | 1 | This pixel is the first of a line |
| ref_pix | input | PIX_W | Current-block pixel broadcast to all elements |
| win_pix | input | (2w+1)*PIX_W | One search-window pixel per element, element k at bits k*PIX_W |
| srch_done | output | 1 | One-cycle pulse: search result valid |
| best_sad | output | PIX_W+clog2(N*N) | Minimum distortion of the search |
| best_m | output | clog2(w+1)+1 | Signed vertical displacement of the minimum |
| best_n | output | clog2(w+1)+1 | Signed horizontal displacement of the minimum |

## Verification
Random current blocks and windows test the summing and the ordering in general. A planted exact copy at the far corner shows that the last element of the last line can win. All-zero data makes every candidate tie, which shows whether the first displacement is kept under strict less-than. Saturated data with the largest difference on every pixel shows whether the distortion wraps. Idle gaps inside lines and lines that are dropped and restarted separate correct hold and clear behaviour from counting by cycles. Searches sent back to back test the overlap of shift-out with the next line's summing.

// File: rtl/sad_pkg.sv
package sad_pkg;

  // state of the result chain feeding the minimum comparator
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;

endpackage

// File: rtl/sad_rst_sync.sv
module sad_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/sad_pe.sv
module sad_pe #(
  parameter int PIX_W = 8,
  parameter int SAD_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [PIX_W-1:0] ref_pix,
  input  logic [PIX_W-1:0] win_pix,
  output logic [SAD_W-1:0] acc_q_o,
  output logic [SAD_W-1:0] acc_d_o
);

  logic [PIX_W-1:0] diff;
  logic [SAD_W-1:0] base;
  logic [SAD_W-1:0] acc_q;
  logic [SAD_W-1:0] acc_d;

  always_comb begin
    diff = (ref_pix > win_pix) ? (ref_pix - win_pix) : (win_pix - ref_pix);
    base = clr ? '0 : acc_q;
    acc_d = en ? (base + SAD_W'(diff)) : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_d;
  end

  assign acc_q_o = acc_q;
  assign acc_d_o = acc_d;

endmodule

// File: rtl/sad_line_ctrl.sv
module sad_line_ctrl #(
  parameter int NN     = 16,
  parameter int NUM_PE = 5,
  parameter int LIN_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic             line_start,
  output logic             line_last,
  output logic [LIN_W-1:0] line_idx
);

  localparam int CNT_W = (NN > 1) ? $clog2(NN) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_eff;
  logic [LIN_W-1:0] line_q, line_d;

  always_comb begin
    cnt_eff   = line_start ? '0 : cnt_q;
    line_last = pix_valid && (cnt_eff == CNT_W'(NN - 1));
    cnt_d     = cnt_q;
    line_d    = line_q;
    if (pix_valid) begin
      cnt_d = line_last ? '0 : (cnt_eff + 1'b1);
    end
    if (line_last) begin
      line_d = (line_q == LIN_W'(NUM_PE - 1)) ? '0 : (line_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      line_q <= '0;
    end else if (pix_valid) begin
      cnt_q  <= cnt_d;
      line_q <= line_d;
    end
  end

  assign line_idx = line_q;

endmodule

// File: rtl/sad_min_scan.sv
module sad_min_scan
  import sad_pkg::*;
#(
  parameter int NUM_PE = 5,
  parameter int SAD_W  = 12,
  parameter int VEC_W  = 3,
  parameter int SRCH_W = 2,
  parameter int LIN_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [LIN_W-1:0]        load_line,
  input  logic [NUM_PE*SAD_W-1:0] snap_in,
  output logic [SAD_W-1:0]        best_sad,
  output logic [VEC_W-1:0]        best_m,
  output logic [VEC_W-1:0]        best_n,
  output logic                    srch_done,
  output logic                    cmp_act,
  output logic                    cmp_first
);

  scan_state_e             st_q, st_d;
  logic [LIN_W-1:0]        pos_q, pos_d;
  logic [LIN_W-1:0]        tag_q, tag_d;
  logic [NUM_PE*SAD_W-1:0] chain_q, chain_d;
  logic                    chain_en;
  logic [SAD_W-1:0]        cand;
  logic                    last_elem, take, done_d;
  logic [VEC_W-1:0]        m_val, n_val;
  logic [SAD_W-1:0]        sad_q;
  logic [VEC_W-1:0]        m_q, n_q;
  logic                    done_q;

  always_comb begin
    st_d      = st_q;
    pos_d     = pos_q;
    tag_d     = tag_q;
    cmp_act   = (st_q == SCAN_RUN);
    last_elem = cmp_act && (pos_q == LIN_W'(NUM_PE - 1));
    if (load) begin
      st_d  = SCAN_RUN;
      pos_d = '0;
      tag_d = load_line;
    end else if (cmp_act) begin
      pos_d = pos_q + 1'b1;
      if (last_elem) begin
        st_d  = SCAN_IDLE;
        pos_d = '0;
      end
    end
    chain_en = load || cmp_act;
    chain_d  = load ? snap_in : (chain_q >> SAD_W);
    cand     = chain_q[SAD_W-1:0];
    cmp_first = cmp_act && (pos_q == '0) && (tag_q == '0);
    take     = cmp_act && (cmp_first || (cand < sad_q));
    done_d   = last_elem && (tag_q == LIN_W'(NUM_PE - 1));
    m_val    = VEC_W'(int'(tag_q) - SRCH_W);
    n_val    = VEC_W'(int'(pos_q) - SRCH_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SCAN_IDLE;
      pos_q <= '0;
      tag_q <= '0;
    end else begin
      st_q  <= st_d;
      pos_q <= pos_d;
      tag_q <= tag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chain_q <= '0;
    else if (chain_en) chain_q <= chain_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sad_q <= '0;
      m_q   <= '0;
      n_q   <= '0;
    end else if (take) begin
      sad_q <= cand;
      m_q   <= m_val;
      n_q   <= n_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign best_sad  = sad_q;
  assign best_m    = m_q;
  assign best_n    = n_q;
  assign srch_done = done_q;

endmodule

// File: rtl/sad_line_array.sv
module sad_line_array #(
  parameter int BLK_N  = 4,
  parameter int SRCH_W = 2,
  parameter int PIX_W  = 8,
  localparam int NUM_PE = 2 * SRCH_W + 1,
  localparam int NN     = BLK_N * BLK_N,
  localparam int SAD_W  = PIX_W + $clog2(NN),
  localparam int VEC_W  = $clog2(SRCH_W + 1) + 1,
  localparam int LIN_W  = $clog2(NUM_PE)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pix_valid,
  input  logic                    line_start,
  input  logic [PIX_W-1:0]        ref_pix,
  input  logic [NUM_PE*PIX_W-1:0] win_pix,
  output logic                    srch_done,
  output logic [SAD_W-1:0]        best_sad,
  output logic signed [VEC_W-1:0] best_m,
  output logic signed [VEC_W-1:0] best_n
);

  logic                    rst_n_s;
  logic                    line_last;
  logic [LIN_W-1:0]        line_idx;
  logic [NUM_PE*SAD_W-1:0] acc_flat;
  logic [NUM_PE*SAD_W-1:0] snap_flat;
  logic                    cmp_act, cmp_first;
  logic [VEC_W-1:0]        m_raw, n_raw;

  sad_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  sad_line_ctrl #(
    .NN     (NN),
    .NUM_PE (NUM_PE),
    .LIN_W  (LIN_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .pix_valid  (pix_valid),
    .line_start (line_start),
    .line_last  (line_last),
    .line_idx   (line_idx)
  );

  for (genvar k = 0; k < NUM_PE; k++) begin : g_pe
    sad_pe #(
      .PIX_W (PIX_W),
      .SAD_W (SAD_W)
    ) u_pe (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .en      (pix_valid),
      .clr     (line_start),
      .ref_pix (ref_pix),
      .win_pix (win_pix[k*PIX_W +: PIX_W]),
      .acc_q_o (acc_flat[k*SAD_W +: SAD_W]),
      .acc_d_o (snap_flat[k*SAD_W +: SAD_W])
    );
  end

  sad_min_scan #(
    .NUM_PE (NUM_PE),
    .SAD_W  (SAD_W),
    .VEC_W  (VEC_W),
    .SRCH_W (SRCH_W),
    .LIN_W  (LIN_W)
  ) u_min (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load      (line_last),
    .load_line (line_idx),
    .snap_in   (snap_flat),
    .best_sad  (best_sad),
    .best_m    (m_raw),
    .best_n    (n_raw),
    .srch_done (srch_done),
    .cmp_act   (cmp_act),
    .cmp_first (cmp_first)
  );

  assign best_m = $signed(m_raw);
  assign best_n = $signed(n_raw);

endmodule

// File: rtl/sad_line_array_chk.sv
module sad_line_array_chk #(
  parameter int PIX_W  = 8,
  parameter int SAD_W  = 12,
  parameter int VEC_W  = 3,
  parameter int SRCH_W = 2,
  parameter int LIN_W  = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pix_valid,
  input logic                    line_start,
  input logic                    srch_done,
  input logic [SAD_W-1:0]        best_sad,
  input logic signed [VEC_W-1:0] best_m,
  input logic signed [VEC_W-1:0] best_n,
  input logic [SAD_W-1:0]        acc0,
  input logic                    cmp_act,
  input logic                    cmp_first,
  input logic [LIN_W-1:0]        line_idx
);

  localparam logic [SAD_W-1:0] ONE_PIX_MAX = SAD_W'((1 << PIX_W) - 1);

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && line_start) |=> (acc0 <= ONE_PIX_MAX)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> $stable(acc0)); // R3

  AST_DONE_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    srch_done |-> (line_idx == '0)); // R4

  AST_MIN_NEVER_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act && !cmp_first) |=> (best_sad <= $past(best_sad))); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    srch_done |=> !srch_done); // R7

  AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    srch_done |-> ((int'(best_m) >= -SRCH_W) && (int'(best_m) <= SRCH_W) &&
                   (int'(best_n) >= -SRCH_W) && (int'(best_n) <= SRCH_W))); // R7

endmodule

bind sad_line_array sad_line_array_chk #(
  .PIX_W  (PIX_W),
  .SAD_W  (SAD_W),
  .VEC_W  (VEC_W),
  .SRCH_W (SRCH_W),
  .LIN_W  (LIN_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .pix_valid  (pix_valid),
  .line_start (line_start),
  .srch_done  (srch_done),
  .best_sad   (best_sad),
  .best_m     (best_m),
  .best_n     (best_n),
  .acc0       (acc_flat[SAD_W-1:0]),
  .cmp_act    (cmp_act),
  .cmp_first  (cmp_first),
  .line_idx   (line_idx)
);

// File: tb/sim_sad_line_array.sv
module sim_sad_line_array;

  localparam int N      = 4;
  localparam int W      = 2;
  localparam int PIX_W  = 8;
  localparam int NP     = 2 * W + 1;
  localparam int SPAN   = N + 2 * W;
  localparam int SAD_W  = PIX_W + $clog2(N * N);
  localparam int VEC_W  = $clog2(W + 1) + 1;

  logic                    clk;
  logic                    rst_n;
  logic                    pix_valid;
  logic                    line_start;
  logic [PIX_W-1:0]        ref_pix;
  logic [NP*PIX_W-1:0]     win_pix;
  logic                    srch_done;
  logic [SAD_W-1:0]        best_sad;
  logic signed [VEC_W-1:0] best_m;
  logic signed [VEC_W-1:0] best_n;

  int checks = 0;
  int errors = 0;
  int dones  = 0;
  int pushed = 0;
  bit finished = 0;

  int    xb [N][N];
  int    yb [SPAN][SPAN];
  int    q_sad [$];
  int    q_m [$];
  int    q_n [$];
  string q_tag [$];

  sad_line_array #(.BLK_N(N), .SRCH_W(W), .PIX_W(PIX_W)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid  (pix_valid),
    .line_start (line_start),
    .ref_pix    (ref_pix),
    .win_pix    (win_pix),
    .srch_done  (srch_done),
    .best_sad   (best_sad),
    .best_m     (best_m),
    .best_n     (best_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // full-search reference, scan order m outer, n inner, strict less-than
  task automatic push_expected(string tag);
    int bs, bm, bn;
    bs = -1; bm = 0; bn = 0;
    for (int m = -W; m <= W; m++) begin
      for (int n = -W; n <= W; n++) begin
        int s;
        s = 0;
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N; j++) begin
            int d;
            d = xb[i][j] - yb[i+m+W][j+n+W];
            s += (d < 0) ? -d : d;
          end
        if (bs < 0 || s < bs) begin
          bs = s; bm = m; bn = n;
        end
      end
    end
    q_sad.push_back(bs);
    q_m.push_back(bm);
    q_n.push_back(bn);
    q_tag.push_back(tag);
    pushed++;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    pix_valid  = 1'b0;
    line_start = 1'b1;
    ref_pix    = 8'hAA;
    win_pix    = '1;
  endtask

  task automatic drive_pix(int l, int i, int j, bit first);
    @(negedge clk);
    pix_valid  = 1'b1;
    line_start = first;
    ref_pix    = PIX_W'(xb[i][j]);
    for (int k = 0; k < NP; k++)
      win_pix[k*PIX_W +: PIX_W] = PIX_W'(yb[i+l][j+k]);
  endtask

  // gaps: idle cycles inside lines (R3); abort_line: partial line restarted (R2)
  task automatic run_search(string tag, bit gaps, int abort_line);
    push_expected(tag);
    for (int l = 0; l < NP; l++) begin
      if (l == abort_line) begin
        for (int p = 0; p < 3; p++) begin
          @(negedge clk);
          pix_valid  = 1'b1;
          line_start = (p == 0);
          ref_pix    = 8'hFF;
          win_pix    = '0;
        end
      end
      for (int j = 0; j < N; j++)
        for (int i = 0; i < N; i++) begin
          drive_pix(l, i, j, (i == 0 && j == 0));
          if (gaps && ((i + j) % 3 == 1)) idle_cycle();
        end
    end
    @(negedge clk);
    pix_valid  = 1'b0;
    line_start = 1'b0;
  endtask

  task automatic fill_random();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) xb[i][j] = $urandom_range(255);
    for (int i = 0; i < SPAN; i++)
      for (int j = 0; j < SPAN; j++) yb[i][j] = $urandom_range(255);
  endtask

  task automatic fill_const(int xv, int yv);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) xb[i][j] = xv;
    for (int i = 0; i < SPAN; i++)
      for (int j = 0; j < SPAN; j++) yb[i][j] = yv;
  endtask

  task automatic plant(int m, int n);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) yb[i+m+W][j+n+W] = xb[i][j];
  endtask

  // monitor: pops expected results as the design reports them
  always @(negedge clk) begin
    if (rst_n && srch_done) begin
      dones++;
      if (q_sad.size() == 0) begin
        chk("R7 unexpected done", 1, 0);
      end else begin
        string t;
        t = q_tag.pop_front();
        chk({t, " R1 R8 best_sad"}, int'(best_sad), q_sad.pop_front());
        chk({t, " R4 R6 best_m"}, int'(best_m), q_m.pop_front());
        chk({t, " R1 R6 best_n"}, int'(best_n), q_n.pop_front());
      end
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n      = 1'b0;
    pix_valid  = 1'b0;
    line_start = 1'b0;
    ref_pix    = '0;
    win_pix    = '0;
    repeat (3) @(negedge clk);
    // R9: reset values while reset is held
    chk("R9 done in reset", int'(srch_done), 0);
    chk("R9 sad in reset", int'(best_sad), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 done after reset", int'(srch_done), 0);
    chk("R9 vector after reset", int'(best_m) + int'(best_n), 0);

    // line_start without pix_valid must not disturb anything (R2 R3)
    @(negedge clk);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;

    fill_random();
    run_search("random1", 0, -1);
    fill_random();
    plant(W, W);
    run_search("R6 corner +w,+w", 0, -1);
    fill_random();
    plant(-1, 2);
    run_search("planted -1,+2", 0, -1);
    fill_const(0, 0);
    run_search("R6 all tie", 0, -1);
    fill_const(255, 0);
    run_search("R8 max sum", 0, -1);
    fill_random();
    run_search("R3 gaps", 1, -1);
    fill_random();
    run_search("R2 abort line0", 0, 0);
    fill_random();
    plant(1, -2);
    run_search("R2 abort line3", 0, 3);

    // R5 R4: two searches fully back to back
    fill_random();
    push_expected("R5 back2back a");
    for (int l = 0; l < NP; l++)
      for (int j = 0; j < N; j++)
        for (int i = 0; i < N; i++) drive_pix(l, i, j, (i == 0 && j == 0));
    fill_random();
    plant(-2, 0);
    run_search("R5 back2back b", 0, -1);

    repeat (3 * NP + 10) @(negedge clk);
    // R7: one pulse per search, none extra
    chk("R7 done count", dones, pushed);
    chk("R7 queue drained", q_sad.size(), 0);
    finish_run();
  end

endmodule